// File: doc/BRIEF.md
# Paced Serial Byte Sender

This block accepts ASCII characters on a valid/ready byte stream and queues them in an on-chip buffer. It sends them out as 8N1 serial frames on a single transmit line. The bit time is the clock rate divided by the baud rate, and both rates are parameters. By default a 50 MHz clock drives the line at 921600 baud, which gives a divisor of 54 cycles per bit.

A serial receiver runs alongside the transmitter on the incoming line. It decodes characters and acts on two of them. Control-S (0x13) pauses the sender. Control-Q (0x11) lets it continue. Every other received character is dropped. While the sender is paused, the buffer holds back the pending output. The default buffer depth is 2048 bytes, and a parameter sets it.

Top module: `uart_flow_tx`

## Requirements
- R1: After reset the transmit line is high, the buffer is empty (`buf_empty`=1, `buf_full`=0), `in_ready` is 1, and sending is enabled.
- R2: Each character goes out as one frame of exactly DIV = CLK_HZ/BAUD cycles per bit: a low start bit, then 8 data bits with bit 0 first, then a high stop bit.
- R3: Characters leave in the order they were accepted. The buffer holds DEPTH characters. When it is full, `buf_full` is 1 and `in_ready` is 0, and input offered while full is dropped.
- R4: When 0x13 is received, no new frame starts. A frame already on the line runs to its stop bit.
- R5: When 0x11 is received, sending resumes with the oldest buffered character.
- R6: A received character other than 0x11 or 0x13 does not change the paused or running state.
- R7: The receiver samples each bit at its middle. A received frame whose stop bit is low is discarded, even when its data bits spell 0x13 or 0x11.
- R8: Once the last buffered character has been taken for sending, `buf_empty` returns to 1, and the transmit line stays high while nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Character to queue |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Buffer can take a character this cycle |
| rxd | input | 1 | Serial receive line (flow-control characters) |
| txd | output | 1 | Serial transmit line |
| buf_full | output | 1 | Buffer holds DEPTH characters |
| buf_empty | output | 1 | Buffer holds no characters |

## Verification
A wrong buffer pointer or count shows up at the ports as wrong output. Characters can arrive out of order, appear twice or go missing. `buf_full` or `buf_empty` can disagree with the number of characters accepted minus the number sent. These errors appear within one frame of the character concerned. A fault in the pause state shows up as one of two things: frames keep starting about one bit time after a stop character is decoded, or the line stays silent after a resume character. A fault in the frame shift logic or bit counter corrupts the very next character, and a monitor sampling at mid-bit sees it at once.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  localparam logic [7:0] CH_RESUME = 8'h11;
  localparam logic [7:0] CH_PAUSE  = 8'h13;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/flow_fifo.sv
module flow_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count, count_nxt;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    count_nxt = count;
    if (do_push && !do_pop)      count_nxt = count + CW'(1);
    else if (do_pop && !do_push) count_nxt = count - CW'(1);
  end

  // storage without reset so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
    if (do_pop)  dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      count <= count_nxt;
      full  <= (count_nxt == CW'(DEPTH));
      empty <= (count_nxt == '0);
    end
  end

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_empty_matches_r8: assert property (@(posedge clk) disable iff (rst)
    empty == (count == '0));
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame #(
  parameter int DIV = 54
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] data,
  output logic       busy,
  output logic       txd
);
  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] baud_cnt;
  logic [3:0]    bits_left;
  logic [8:0]    shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      txd       <= 1'b1;
      baud_cnt  <= '0;
      bits_left <= '0;
      shreg     <= '1;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        txd       <= 1'b0;
        shreg     <= {1'b1, data};
        bits_left <= 4'd9;
        baud_cnt  <= CW'(DIV - 1);
      end
    end else if (baud_cnt != '0) begin
      baud_cnt <= baud_cnt - CW'(1);
    end else if (bits_left == 4'd0) begin
      busy <= 1'b0;
    end else begin
      txd       <= shreg[0];
      shreg     <= {1'b1, shreg[8:1]};
      bits_left <= bits_left - 4'd1;
      baud_cnt  <= CW'(DIV - 1);
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  p_stop_bit_high_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> txd);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_flow_pkg::*;
#(
  parameter int DIV = 54
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  localparam int CW = $clog2(DIV + 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (state != RX_IDLE && cnt != '0) begin
        cnt <= cnt - CW'(1);
      end else begin
        unique case (state)
          RX_IDLE: if (!rx) begin
            state <= RX_START;
            cnt   <= CW'(DIV / 2 - 1);
          end
          RX_START: if (!rx) begin
            state   <= RX_DATA;
            bit_idx <= '0;
            cnt     <= CW'(DIV - 1);
          end else begin
            state <= RX_IDLE;
          end
          RX_DATA: begin
            shreg   <= {rx, shreg[7:1]};
            cnt     <= CW'(DIV - 1);
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) state <= RX_STOP;
          end
          RX_STOP: begin
            state <= RX_IDLE;
            if (rx) begin
              byte_valid <= 1'b1;
              byte_data  <= shreg;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
  p_valid_needs_stop_r7: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(rx));
endmodule

// File: rtl/uart_flow_tx.sv
module uart_flow_tx
  import uart_flow_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 921_600,
  parameter int DEPTH  = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       rxd,
  output logic       txd,
  output logic       buf_full,
  output logic       buf_empty
);
  localparam int DIV = CLK_HZ / BAUD;

  logic       rx_m, rx_s;
  logic       run;
  logic       fetch;
  logic       pop;
  logic [7:0] fifo_dout;
  logic       tx_busy;
  logic       rx_valid;
  logic [7:0] rx_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  assign in_ready = !buf_full;
  assign pop      = run && !fetch && !tx_busy && !buf_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b1;
      fetch <= 1'b0;
    end else begin
      fetch <= pop;
      if (rx_valid && rx_byte == CH_PAUSE)  run <= 1'b0;
      if (rx_valid && rx_byte == CH_RESUME) run <= 1'b1;
    end
  end

  flow_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (in_valid),
    .din   (in_data),
    .pop   (pop),
    .dout  (fifo_dout),
    .full  (buf_full),
    .empty (buf_empty)
  );

  uart_tx_frame #(.DIV(DIV)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .start (fetch),
    .data  (fifo_dout),
    .busy  (tx_busy),
    .txd   (txd)
  );

  uart_rx_frame #(.DIV(DIV)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx         (rx_s),
    .byte_valid (rx_valid),
    .byte_data  (rx_byte)
  );

  p_start_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    fetch |-> !tx_busy);
  p_hold_when_paused_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !fetch) |=> !fetch);
  p_resume_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_byte == CH_RESUME) |=> run);
  p_pause_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_byte == CH_PAUSE) |=> !run);
endmodule

// File: tb/uart_flow_tx_test.sv
module uart_flow_tx_test;
  localparam int CLK_HZ = 8_000_000;
  localparam int BAUD   = 1_000_000;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam int DEPTH  = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       rxd = 1'b1;
  logic       txd;
  logic       buf_full, buf_empty;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  always #2 clk = ~clk;

  uart_flow_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .rxd(rxd), .txd(txd),
    .buf_full(buf_full), .buf_empty(buf_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [9:0] frame_bits(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  // line monitor: samples the transmit line in the middle of each bit (R2)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !txd) begin
        logic [9:0] f;
        repeat (DIV / 2) @(negedge clk);
        f[0] = txd;
        for (int i = 1; i < 10; i++) begin
          repeat (DIV) @(negedge clk);
          f[i] = txd;
        end
        check(f[0] == 1'b0 && f[9] == 1'b1, "R2 frame start/stop", f[9:0], frame_bits(f[8:1]));
        got_q.push_back(f[8:1]);
      end
    end
  end

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic try_push(input logic [7:0] b);
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    if (in_ready) exp_q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input bit stop_ok);
    logic [9:0] f;
    f = {stop_ok, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rxd = f[i];
      repeat (DIV - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (2 * DIV) @(negedge clk);
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    while (quiet < 12 * DIV) begin
      @(negedge clk);
      if (buf_empty && txd) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic compare(input string req);
    check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd idle", txd, 1);
    check(buf_empty == 1'b1, "R1 empty", buf_empty, 1);
    check(buf_full == 1'b0, "R1 full", buf_full, 0);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);

    // R2 directed patterns, then R3 random order
    push_byte(8'hA5);
    push_byte(8'h00);
    push_byte(8'hFF);
    push_byte(8'h01);
    push_byte(8'h80);
    wait_quiet();
    compare("R2 directed bytes");
    for (int i = 0; i < 30; i++) begin
      push_byte(8'($urandom));
      if ($urandom % 3 == 0) wait_cycles($urandom % (3 * DIV));
    end
    wait_quiet();
    compare("R3 random order");
    check(buf_empty == 1'b1 && txd == 1'b1, "R8 empty after drain", buf_empty, 1);

    // R4 pause while idle, R6 stray byte, R5 resume
    send_rx(8'h13, 1'b1);
    for (int i = 0; i < 5; i++) push_byte(8'($urandom));
    wait_cycles(30 * DIV);
    check(got_q.size() == 0, "R4 paused no frames", got_q.size(), 0);
    check(buf_empty == 1'b0, "R4 data held", buf_empty, 0);
    send_rx(8'h41, 1'b1);
    wait_cycles(20 * DIV);
    check(got_q.size() == 0, "R6 stray byte keeps pause", got_q.size(), 0);
    send_rx(8'h11, 1'b1);
    wait_quiet();
    compare("R5 resume order");

    // R4 pause during a frame: current frame completes, one more started
    for (int i = 0; i < 6; i++) push_byte(8'($urandom));
    while (txd) @(negedge clk);
    wait_cycles(4 * DIV);
    send_rx(8'h13, 1'b1);
    wait_cycles(30 * DIV);
    check(got_q.size() == 2, "R4 in-flight frame completes", got_q.size(), 2);
    check(buf_empty == 1'b0 && txd == 1'b1, "R4 halted", txd, 1);
    send_rx(8'h22, 1'b1);
    wait_cycles(20 * DIV);
    check(got_q.size() == 2, "R6 stray byte while paused", got_q.size(), 2);

    // R3 full: fill while paused
    for (int i = 0; i < DEPTH + 4; i++) try_push(8'($urandom));
    check(buf_full == 1'b1, "R3 full flag", buf_full, 1);
    check(in_ready == 1'b0, "R3 ready low when full", in_ready, 0);
    check(exp_q.size() == DEPTH + 2, "R3 accepted count", exp_q.size(), DEPTH + 2);

    // R7 resume with bad stop bit is discarded
    send_rx(8'h11, 1'b0);
    wait_cycles(30 * DIV);
    check(got_q.size() == 2, "R7 bad stop ignored", got_q.size(), 2);
    send_rx(8'h11, 1'b1);
    wait_quiet();
    compare("R3 drain after full");

    // R7 pause with bad stop bit does not pause; R6 stray byte while running
    send_rx(8'h13, 1'b0);
    send_rx(8'h5A, 1'b1);
    for (int i = 0; i < 4; i++) push_byte(8'($urandom));
    wait_quiet();
    compare("R7 bad-stop pause ignored");
    check(buf_empty == 1'b1 && buf_full == 1'b0, "R8 flags after drain", buf_empty, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule